// File: doc/BRIEF.md
# Byte-Serial CRC-32 Engine with Residue Check

This block computes the common CRC-32 over a stream of bytes, one byte per clock. The value it reports is bit-for-bit the same as the usual software routine that uses the reflected polynomial, an all-ones start value and a final complement. It also works as a receive-side checker. When a frame is followed by its own CRC, the running register ends at a fixed constant, and a registered flag reports a good frame.

Inside, the CRC register is kept in plain, non-reflected form and shifts most-significant bit first. Each clock the register takes the polynomial feedback eight times, and the taps are not changed. The reordering needed to match software is done at the edges of the block. Each incoming byte is fed least-significant bit first. The outgoing word is complemented and then fully bit-reversed.

A frame begins with a start-of-frame pulse, given together with its first byte or alone. The bytes that follow are qualified by a valid strobe, and gaps are allowed.

Top module: `crc32_refl_engine`

## Requirements
- R1: While reset is high and on the first cycle after it falls, `crc_o` reads 0x00000000 and `pass_o` reads 0.
- R2: A start-of-frame pulse presets the register to all ones. If `valid_i` is high in the same cycle, that byte is folded into the preset value. A pulse with `valid_i` low leaves `crc_o` at 0x00000000, which is the CRC of an empty frame.
- R3: Each accepted byte advances the register by eight steps of the polynomial 0x04C11DB7, taking bit 0 of `data_i` first and bit 7 last, all within one clock.
- R4: `crc_o` is the bit reversal of the complemented register. It shows the effect of a byte on the cycle after that byte is accepted.
- R5: The nine ASCII bytes "123456789" (0x31 to 0x39) give `crc_o` = 0xCBF43926.
- R6: A cycle in which both `valid_i` and `sof_i` are low changes neither `crc_o` nor `pass_o`.
- R7: Send a message, then the `crc_o` value it produced, least-significant byte first. The register then holds the residue 0xC704DD7B, and `pass_o` is 1 on the cycle after the last CRC byte.
- R8: If any bit of the appended CRC is wrong, `pass_o` is 0 after the last byte.
- R9: `sof_i` forces `pass_o` to 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sof_i | input | 1 | Start of frame: presets the register |
| valid_i | input | 1 | Data byte qualifier |
| data_i | input | 8 | Data byte, bit 0 processed first |
| crc_o | output | 32 | Software-convention CRC of the bytes so far |
| pass_o | output | 1 | Registered good-frame flag (residue match) |

## Verification
A wrong internal register value shows on `crc_o` one cycle after the byte that caused it, because the output is a fixed rearrangement of the register. The sweep over all 256 single-byte frames compares `crc_o` against an independent reflected software model after every frame, and it also exercises all eight feedback steps. A feedback or bit-order error that cancels out in `crc_o` cannot also hit the residue. It therefore shows on `pass_o` one cycle after the fourth appended CRC byte, and corrupted tails check that the flag stays low.

// File: rtl/crc32_pkg.sv
package crc32_pkg;
    localparam int CRC_W  = 32;
    localparam int BYTE_W = 8;

    localparam logic [CRC_W-1:0] POLY    = 32'h04C11DB7;
    localparam logic [CRC_W-1:0] PRESET  = 32'hFFFFFFFF;
    localparam logic [CRC_W-1:0] RESIDUE = 32'hC704DD7B;

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic  sof;
        logic  valid;
        byte_t data;
    } beat_t;

    // One serial step of the non-reflected LFSR
    function automatic crc_t lfsr_step(input crc_t s, input logic b);
        logic fb;
        fb = s[CRC_W-1] ^ b;
        return {s[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    endfunction

    function automatic crc_t reflect(input crc_t v);
        crc_t r;
        for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
        return r;
    endfunction
endpackage

// File: rtl/crc32_byte_fold.sv
module crc32_byte_fold
    import crc32_pkg::*;
#(
    parameter int W = BYTE_W
) (
    input  crc_t         cur_i,
    input  logic [W-1:0] d_i,
    output crc_t         nxt_o
);
    crc_t acc;
    always_comb begin
        acc = cur_i;
        // bit 0 of the byte enters first: reflection at the byte boundary
        for (int i = 0; i < W; i++) acc = lfsr_step(acc, d_i[i]);
        nxt_o = acc;
    end
endmodule

// File: rtl/crc32_lfsr_reg.sv
module crc32_lfsr_reg
    import crc32_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  beat_t beat_i,
    output crc_t  state_o,
    output crc_t  next_o
);
    crc_t state_q;
    crc_t base;
    crc_t folded;

    always_comb base = beat_i.sof ? PRESET : state_q;

    crc32_byte_fold #(.W(BYTE_W)) fold_i (
        .cur_i(base),
        .d_i  (beat_i.data),
        .nxt_o(folded)
    );

    always_ff @(posedge clk) begin
        if (rst)               state_q <= PRESET;
        else if (beat_i.valid) state_q <= folded;
        else if (beat_i.sof)   state_q <= PRESET;
    end

    assign state_o = state_q;
    assign next_o  = folded;

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!beat_i.valid && !beat_i.sof) |=> $stable(state_q));
    assert_sof_preset_R2: assert property (@(posedge clk) disable iff (rst)
        (beat_i.sof && !beat_i.valid) |=> (state_q == PRESET));
endmodule

// File: rtl/crc32_residue_flag.sv
module crc32_residue_flag
    import crc32_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sof_i,
    input  logic valid_i,
    input  crc_t next_i,
    output logic pass_o
);
    logic pass_q;

    always_ff @(posedge clk) begin
        if (rst || sof_i) pass_q <= 1'b0;
        else if (valid_i) pass_q <= (next_i == RESIDUE);
    end

    assign pass_o = pass_q;

    assert_sof_clears_pass_R9: assert property (@(posedge clk) disable iff (rst)
        sof_i |=> !pass_q);
    assert_pass_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!valid_i && !sof_i) |=> $stable(pass_q));
endmodule

// File: rtl/crc32_out_fmt.sv
module crc32_out_fmt
    import crc32_pkg::*;
(
    input  crc_t state_i,
    output crc_t word_o
);
    assign word_o = reflect(~state_i);
endmodule

// File: rtl/crc32_refl_engine.sv
module crc32_refl_engine
    import crc32_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sof_i,
    input  logic        valid_i,
    input  logic [7:0]  data_i,
    output logic [31:0] crc_o,
    output logic        pass_o
);
    beat_t beat;
    crc_t  state;
    crc_t  next_crc;

    assign beat = '{sof: sof_i, valid: valid_i, data: data_i};

    crc32_lfsr_reg reg_i (
        .clk    (clk),
        .rst    (rst),
        .beat_i (beat),
        .state_o(state),
        .next_o (next_crc)
    );

    crc32_residue_flag chk_i (
        .clk    (clk),
        .rst    (rst),
        .sof_i  (sof_i),
        .valid_i(valid_i),
        .next_i (next_crc),
        .pass_o (pass_o)
    );

    crc32_out_fmt fmt_i (
        .state_i(state),
        .word_o (crc_o)
    );

    assert_pass_means_residue_R7: assert property (@(posedge clk) disable iff (rst)
        pass_o |-> (state == RESIDUE));
    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (crc_o == 32'h0 && !pass_o));
endmodule

// File: tb/crc32_refl_engine_tb_top.sv
module crc32_refl_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sof_i = 1'b0;
    logic        valid_i = 1'b0;
    logic [7:0]  data_i = 8'h00;
    logic [31:0] crc_o;
    logic        pass_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [7:0] msg [0:15];

    always #4 clk = ~clk;  // 125 MHz

    crc32_refl_engine dut_i (
        .clk(clk), .rst(rst), .sof_i(sof_i), .valid_i(valid_i),
        .data_i(data_i), .crc_o(crc_o), .pass_o(pass_o)
    );

    // Reflected software model, LSB-first, polynomial 0xEDB88320
    function automatic logic [31:0] sw_crc(input int len);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < len; i++) begin
            c = c ^ {24'h0, msg[i]};
            for (int k = 0; k < 8; k++)
                c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic push(input logic s, input logic [7:0] d);
        sof_i = s; valid_i = 1'b1; data_i = d;
        @(negedge clk);
        sof_i = 1'b0; valid_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send_msg(input int len);
        for (int i = 0; i < len; i++) push(i == 0, msg[i]);
    endtask

    task automatic send_crc(input logic [31:0] c);
        for (int i = 0; i < 4; i++) push(1'b0, c[8*i +: 8]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] got;
        logic [31:0] mid;
        repeat (3) @(negedge clk);
        chk("R1 crc during reset", crc_o, 32'h0);
        chk("R1 pass during reset", {31'h0, pass_o}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 crc after reset", crc_o, 32'h0);
        chk("R1 pass after reset", {31'h0, pass_o}, 32'h0);

        // R5 check string
        for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
        send_msg(9);
        chk("R5 check value", crc_o, 32'hCBF43926);
        chk("R4 matches model", crc_o, sw_crc(9));
        got = crc_o;
        send_crc(got);
        chk("R7 pass after check string", {31'h0, pass_o}, 32'h1);

        // R6 idle keeps pass and crc
        idle(3);
        chk("R6 pass held", {31'h0, pass_o}, 32'h1);
        chk("R6 crc held", crc_o, 32'hFFFFFFFF ^ {<<{32'hC704DD7B}});

        // R9 / R2 sof alone
        sof_i = 1'b1; @(negedge clk); sof_i = 1'b0;
        chk("R9 sof clears pass", {31'h0, pass_o}, 32'h0);
        chk("R2 empty frame crc", crc_o, 32'h0);

        // R3 / R7 / R8 sweep every single-byte frame
        for (int b = 0; b < 256; b++) begin
            msg[0] = 8'(b);
            send_msg(1);
            chk("R3 single byte crc", crc_o, sw_crc(1));
            got = crc_o;
            send_crc(got);
            chk("R7 single byte pass", {31'h0, pass_o}, 32'h1);
            if (b % 16 == 0) begin
                send_msg(1);
                send_crc(got ^ (32'h1 << (b % 32)));
                chk("R8 corrupted tail", {31'h0, pass_o}, 32'h0);
            end
        end

        // R6 gaps inside a frame; R2 back-to-back frames
        for (int i = 0; i < 6; i++) msg[i] = 8'hA5 ^ 8'(i * 37);
        push(1'b1, msg[0]); push(1'b0, msg[1]); push(1'b0, msg[2]);
        mid = crc_o;
        idle(4);
        chk("R6 crc stable over gap", crc_o, mid);
        push(1'b0, msg[3]); idle(1); push(1'b0, msg[4]); push(1'b0, msg[5]);
        chk("R6 gapped frame crc", crc_o, sw_crc(6));
        msg[0] = 8'h5A; msg[1] = 8'hC3;
        send_msg(2);
        chk("R2 restart without gap", crc_o, sw_crc(2));
        got = crc_o;
        send_crc(got);
        chk("R7 two byte pass", {31'h0, pass_o}, 32'h1);
        push(1'b1, 8'h00);
        chk("R9 sof with byte clears pass", {31'h0, pass_o}, 32'h0);
        msg[0] = 8'h00;
        chk("R2 sof with byte folds on preset", crc_o, sw_crc(1));

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule